// File: doc/BRIEF.md
# Ethernet Receive Destination Address Classifier

This block watches the byte stream of a received Ethernet frame and decides whether the frame is kept and why. From the first bytes after the start delimiter it captures the destination address and runs a CRC-32 over it. The top bits of that CRC pick one bit of a programmable logical (hash) filter. When the frame ends, the block reports one of three reasons for accepting it: the destination equals the station address, the hash filter passed it, or it is a broadcast. It also reports the accept decision itself.

The configuration inputs shape the decision. A promiscuous enable keeps every frame. A separate bit decides whether a broadcast may be reported as a hash hit. An external agent can veto frames that match nothing. It does so by pulling an active-low reject pin during a fixed window of bytes from the frame start. The result appears as a one-cycle strobe with the accept bit and the three flags.

Top module: `rx_addr_classifier`

## Requirements
- R1: After reset, and in every cycle in which `done` is low, `accept`, `phys_match`, `hash_match` and `bcast_match` are all 0.
- R2: `done` is high for exactly the one cycle after the cycle in which `rx_eof` is sampled high.
- R3: A destination equal to `station_addr` sets `phys_match` alone and accepts the frame. The first destination byte after the start delimiter is held in bits [7:0] and byte k in bits [8k+7:8k].
- R4: The hash index is bits [31:26] of the CRC register after the 6 destination bytes, read with bit 31 as the MSB. The CRC register starts at all ones, takes bits LSB first, shifts right, and XORs in 0xEDB88320 when the outgoing bit differs from the input bit. It is not inverted at the end. A non-broadcast destination with bit 0 set and `hash_filter[index]` = 1 sets `hash_match` alone. A destination with bit 0 clear never sets `hash_match`.
- R5: A broadcast destination (all ones) with `bcast_hash_en` = 0 sets `bcast_match` alone. This holds whatever the hash filter holds.
- R6: A broadcast destination with `bcast_hash_en` = 1 sets `hash_match` alone when its filter bit is 1. It sets `bcast_match` alone when that bit is 0.
- R7: With `promisc_en` = 1, every frame is accepted. A frame that matches nothing reports all three flags clear.
- R8: With `promisc_en` = 0 and `xrej_en` = 1, a frame that matches nothing is accepted with all flags clear. The exception is `xrej_n` sampled low during the frame's reject window, which rejects the frame.
- R9: The reject window covers the cycle of the first frame byte and every later cycle until `WIN_BYTES` bytes have been received. A low `xrej_n` after that has no effect.
- R10: With `promisc_en` = 0 and `xrej_en` = 0, a frame that matches nothing is rejected, and `xrej_n` has no effect.
- R11: A veto never rejects a frame that sets any of the three flags.
- R12: At most one of the three flags is high in any `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | `rx_data` carries a frame byte this cycle |
| rx_sof | input | 1 | With `rx_valid`, marks the first byte after the start delimiter |
| rx_data | input | 8 | Received frame byte |
| rx_eof | input | 1 | Frame end pulse, given in a cycle with no byte |
| station_addr | input | 48 | Own station address, byte k in bits [8k+7:8k] |
| hash_filter | input | 64 | Logical address filter, one bit per hash index |
| promisc_en | input | 1 | Accept every frame |
| bcast_hash_en | input | 1 | Let a broadcast report a hash match |
| xrej_en | input | 1 | Enable the external reject path |
| xrej_n | input | 1 | External reject, active low |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame is kept |
| phys_match | output | 1 | Station address matched |
| hash_match | output | 1 | Logical filter matched |
| bcast_match | output | 1 | Broadcast matched |

## Verification
The bench builds the classifier with `WIN_BYTES` = 8 and keeps the 6-byte address and the 64-bit filter. With a 12-byte frame, this puts the reject pulse both inside and past the window: every byte position of the frame is swept, so the closing edge of the window is checked exactly. Every combination of the promiscuous, broadcast-hash and reject-enable bits is crossed with five address classes, both with and without a veto. Many random multicast addresses are then run against filters that hold a single set bit. This reaches every hash index and checks that the CRC selects the right filter bit.

// File: rtl/rxac_pkg.sv
package rxac_pkg;

  // Reflected CRC-32 polynomial, bits fed LSB first
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic phys;
    logic hash;
    logic bcast;
  } match_t;

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] r;
    r = c_in;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxac_capture.sv
module rxac_capture #(
  parameter int ADDR_BYTES = 6,
  parameter int WIN_BYTES  = 64,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int CNT_W     = $clog2(WIN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic              xrej_en,
  input  logic              xrej_n,
  output logic [ADDR_W-1:0] da,
  output logic              veto,
  output logic              addr_byte_en,
  output logic              addr_start
);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             veto_q, veto_d;
  logic             first, open, in_win;
  logic [CNT_W-1:0] pos;

  always_comb begin
    first        = rx_valid && rx_sof;
    pos          = first ? '0 : cnt_q;
    open         = first || active_q;
    in_win       = open && (pos < CNT_W'(WIN_BYTES));
    addr_byte_en = rx_valid && open && (pos < CNT_W'(ADDR_BYTES));
    addr_start   = first;

    active_d = active_q;
    if (first)       active_d = 1'b1;
    else if (rx_eof) active_d = 1'b0;

    cnt_d = cnt_q;
    if (first)
      cnt_d = CNT_W'(1);
    else if (active_q && rx_valid && (cnt_q < CNT_W'(WIN_BYTES)))
      cnt_d = cnt_q + CNT_W'(1);

    veto_d = veto_q;
    if (first)
      veto_d = xrej_en && !xrej_n;
    else if (in_win && xrej_en && !xrej_n)
      veto_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      veto_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      veto_q   <= veto_d;
    end
  end

  // One register lane per destination byte
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_we;
    assign lane_we = addr_byte_en && (pos == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_we) lane_q <= rx_data;
    end
    assign da[8*i +: 8] = lane_q;
  end

  assign veto = veto_q;

endmodule

// File: rtl/rxac_crc.sv
module rxac_crc #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_en,
  input  logic                 start,
  input  logic [7:0]           data,
  output logic [HASH_BITS-1:0] hash_idx
);
  import rxac_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (byte_en) crc_d = crc_byte(start ? 32'hFFFF_FFFF : crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else        crc_q <= crc_d;
  end

  assign hash_idx = crc_q[31 -: HASH_BITS];

endmodule

// File: rtl/rxac_decide.sv
module rxac_decide #(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6,
  localparam int FILT_W   = 1 << HASH_BITS
) (
  input  logic [ADDR_W-1:0]    da,
  input  logic [ADDR_W-1:0]    station,
  input  logic [FILT_W-1:0]    filter,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic                 promisc_en,
  input  logic                 bcast_hash_en,
  input  logic                 xrej_en,
  input  logic                 veto,
  output logic                 accept,
  output rxac_pkg::match_t     flags
);

  logic is_bc, is_self, hit;

  always_comb begin
    is_bc   = &da;
    is_self = (da == station);
    hit     = da[0] && filter[hash_idx];

    flags = '0;
    if (is_self)
      flags.phys = 1'b1;
    else if (is_bc) begin
      if (bcast_hash_en && hit) flags.hash  = 1'b1;
      else                      flags.bcast = 1'b1;
    end else if (hit)
      flags.hash = 1'b1;

    accept = flags.phys || flags.hash || flags.bcast || promisc_en || (xrej_en && !veto);
  end

endmodule

// File: rtl/rx_addr_classifier.sv
module rx_addr_classifier #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int WIN_BYTES  = 64,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int FILT_W    = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [FILT_W-1:0] hash_filter,
  input  logic              promisc_en,
  input  logic              bcast_hash_en,
  input  logic              xrej_en,
  input  logic              xrej_n,
  output logic              done,
  output logic              accept,
  output logic              phys_match,
  output logic              hash_match,
  output logic              bcast_match
);
  import rxac_pkg::*;

  logic [ADDR_W-1:0]    da_w;
  logic                 veto_w, byte_en_w, start_w;
  logic [HASH_BITS-1:0] idx_w;
  logic                 acc_w;
  match_t               flags_w;

  logic   done_q, done_d, acc_q, acc_d;
  match_t flags_q, flags_d;

  rxac_capture #(.ADDR_BYTES(ADDR_BYTES), .WIN_BYTES(WIN_BYTES)) u_capture (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .rx_eof(rx_eof), .xrej_en(xrej_en), .xrej_n(xrej_n),
    .da(da_w), .veto(veto_w), .addr_byte_en(byte_en_w), .addr_start(start_w)
  );

  rxac_crc #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en_w), .start(start_w),
    .data(rx_data), .hash_idx(idx_w)
  );

  rxac_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_decide (
    .da(da_w), .station(station_addr), .filter(hash_filter), .hash_idx(idx_w),
    .promisc_en(promisc_en), .bcast_hash_en(bcast_hash_en), .xrej_en(xrej_en),
    .veto(veto_w), .accept(acc_w), .flags(flags_w)
  );

  always_comb begin
    done_d  = rx_eof;
    acc_d   = rx_eof && acc_w;
    flags_d = rx_eof ? flags_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      done_q  <= done_d;
      acc_q   <= acc_d;
      flags_q <= flags_d;
    end
  end

  assign done        = done_q;
  assign accept      = acc_q;
  assign phys_match  = flags_q.phys;
  assign hash_match  = flags_q.hash;
  assign bcast_match = flags_q.bcast;

endmodule

// File: rtl/rxac_checker.sv
module rxac_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_eof,
  input logic              done,
  input logic              accept,
  input logic              phys_match,
  input logic              hash_match,
  input logic              bcast_match,
  input logic              promisc_en,
  input logic              bcast_hash_en,
  input logic [ADDR_W-1:0] da,
  input logic [ADDR_W-1:0] station
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !accept && !phys_match && !hash_match && !bcast_match); // R1

  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof |=> done); // R2

  AST_PHYS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phys_match == ($past(da) == $past(station)))); // R3

  AST_BCAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(bcast_hash_en) && $past(&da) && ($past(da) != $past(station))
      |-> bcast_match && !hash_match); // R5

  AST_PROMISC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(promisc_en) |-> accept); // R7

  AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    done && (phys_match || hash_match || bcast_match) |-> accept); // R11

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({phys_match, hash_match, bcast_match})); // R12

endmodule

bind rx_addr_classifier rxac_checker #(.ADDR_W(ADDR_W)) u_rxac_checker (
  .clk(clk), .rst_n(rst_n), .rx_eof(rx_eof), .done(done), .accept(accept),
  .phys_match(phys_match), .hash_match(hash_match), .bcast_match(bcast_match),
  .promisc_en(promisc_en), .bcast_hash_en(bcast_hash_en),
  .da(da_w), .station(station_addr)
);

// File: tb/rx_addr_classifier_bench.sv
`timescale 1ns/1ps
module rx_addr_classifier_bench;

  localparam int WIN    = 8;
  localparam int FLEN   = 12;
  localparam logic [47:0] STATION = 48'h5566_7788_2A02;

  logic        clk, rst_n;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic [63:0] hash_filter;
  logic        promisc_en, bcast_hash_en, xrej_en, xrej_n;
  logic        done, accept, phys_match, hash_match, bcast_match;

  int vectors = 0;
  int fails   = 0;

  rx_addr_classifier #(.ADDR_BYTES(6), .HASH_BITS(6), .WIN_BYTES(WIN)) u_rx_addr_classifier (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .rx_eof(rx_eof), .station_addr(station_addr), .hash_filter(hash_filter),
    .promisc_en(promisc_en), .bcast_hash_en(bcast_hash_en), .xrej_en(xrej_en),
    .xrej_n(xrej_n), .done(done), .accept(accept), .phys_match(phys_match),
    .hash_match(hash_match), .bcast_match(bcast_match)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Hash index from R4: CRC over 48 address bits, bit 0 of byte 0 first
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[0] ^ a[k];
      c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return c[31:26];
  endfunction

  // Expected {done, accept, phys, hash, bcast}
  function automatic logic [4:0] model(input logic [47:0] a, input logic vetoed);
    logic p, h, b, hit;
    p = 0; h = 0; b = 0;
    hit = a[0] && hash_filter[ref_idx(a)];
    if (a == station_addr) p = 1;
    else if (a == 48'hFFFF_FFFF_FFFF) begin
      if (bcast_hash_en && hit) h = 1; else b = 1;
    end else if (hit) h = 1;
    return {1'b1, p | h | b | promisc_en | (xrej_en & ~vetoed), p, h, b};
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  // Sends one frame, xrej_n low during byte rej_at (-1: never), checks result
  task automatic frame(input string req, input logic [47:0] a, input int rej_at);
    logic [4:0] exp;
    for (int i = 0; i < FLEN; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_data  = (i < 6) ? a[8*i +: 8] : 8'($urandom);
      xrej_n   = (i == rej_at) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; xrej_n = 1'b1; rx_eof = 1'b1;
    exp = model(a, (rej_at >= 0) && (rej_at < WIN));
    @(negedge clk);
    rx_eof = 1'b0;
    check(req, {done, accept, phys_match, hash_match, bcast_match}, exp);
    @(negedge clk);
    check("R2 strobe one cycle", {done, accept, phys_match, hash_match, bcast_match}, 5'b0);
  endtask

  function automatic logic [47:0] rand_addr(input logic mc);
    logic [47:0] a;
    a = {$urandom, $urandom};
    a[0] = mc;
    if (!mc && a == STATION) a[8] = ~a[8];
    if (a == 48'hFFFF_FFFF_FFFF) a[4] = 1'b0;
    return a;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix, bix;
    string       tag;
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = '0;
    station_addr = STATION; hash_filter = '0;
    promisc_en = 0; bcast_hash_en = 0; xrej_en = 0; xrej_n = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", {done, accept, phys_match, hash_match, bcast_match}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {done, accept, phys_match, hash_match, bcast_match}, 5'b0);

    bix = ref_idx(48'hFFFF_FFFF_FFFF);

    // Configuration sweep crossed with address classes and veto
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int cls = 0; cls < 5; cls++) begin
        for (int rj = 0; rj < 2; rj++) begin
          promisc_en    = cfg[0];
          bcast_hash_en = cfg[1];
          xrej_en       = cfg[2];
          hash_filter   = {$urandom, $urandom};
          case (cls)
            0: begin a = STATION; tag = "R3 R11 phys"; end
            1: begin
              a = 48'hFFFF_FFFF_FFFF;
              hash_filter[bix] = cfg[3];
              tag = cfg[1] ? "R6 bcast hash" : "R5 bcast";
            end
            2: begin
              a = rand_addr(1'b0);
              tag = cfg[0] ? "R7 promisc" : (cfg[2] ? "R8 xrej" : "R10 no match");
            end
            3: begin
              a = rand_addr(1'b1);
              hash_filter[ref_idx(a)] = 1'b1;
              tag = "R4 R11 mc hit";
            end
            default: begin
              a = rand_addr(1'b1);
              hash_filter[ref_idx(a)] = 1'b0;
              tag = "R4 R7 R8 R10 mc miss";
            end
          endcase
          frame(tag, a, rj ? 2 : -1);
        end
      end
    end

    // Reject window boundary: every byte position of the frame
    promisc_en = 0; bcast_hash_en = 0; xrej_en = 1;
    for (int p = 0; p < FLEN; p++) begin
      hash_filter = '0;
      frame((p < WIN) ? "R8 veto in window" : "R9 veto past window", rand_addr(1'b0), p);
    end
    xrej_en = 0;
    frame("R10 xrej ignored when disabled", rand_addr(1'b1), 1);

    // Hash index sweep with one-hot filters
    for (int n = 0; n < 256; n++) begin
      a  = rand_addr(1'b1);
      ix = ref_idx(a);
      hash_filter = '0;
      hash_filter[n[0] ? ix : 6'(n >> 2)] = 1'b1;
      frame("R4 hash index", a, -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule